// File: doc/BRIEF.md
# SPI Serial Clock Rate Selector

This block derives the serial clock of an SPI host from a 200 MHz reference. Software writes two configuration words. The first carries a 4-bit rate code and a full-rate enable bit. The second carries a 6-bit programmable divisor. The rate code either names one of six preset reference divisors or, with code 7, hands the division to the programmable field. The result is a serial clock rate between 800 kHz and 100 MHz.

The downstream shift engine holds `busy_i` high for the length of a frame. While `busy_i` is high, the block emits a one-cycle `tick_o` on every serial clock edge and drives a registered serial clock level on `sck_o`. While `busy_i` is low, the block takes up the newly decoded divisor and rearms its phase counter. A rate change therefore only ever starts at a frame boundary, and no clock phase is ever shortened.

Top module: `sck_rate_sel`

## Requirements
- R1: After reset, `tick_o` and `sck_o` are low, and the rate code defaults to 5, which gives a period of 250 reference cycles.
- R2: A write with `ena_we_i` takes the rate code from `ena_wdata_i[23:20]` and the full-rate enable from `ena_wdata_i[0]`. A write with `spd_we_i` takes the programmable divisor from `spd_wdata_i[13:8]`.
- R3: Rate codes 0, 1, 2 and 3 give serial clock periods of 3, 6, 9 and 12 reference cycles.
- R4: Rate code 4 gives a period of 2 reference cycles when the full-rate enable is 1. When the enable is 0, code 4 gives 250 reference cycles.
- R5: Rate code 5 gives a period of 250 reference cycles (800 kHz).
- R6: Rate code 7 gives a period equal to the programmable divisor field (4 gives 50 MHz, 50 gives 4 MHz, 63 gives about 3.17 MHz). A field value of 0 or 1 gives 2.
- R7: Rate codes 6 and 8 to 15 give a period of 250 reference cycles.
- R8: For a period of d cycles, the first `tick_o` comes d-ceil(d/2)+... precisely: it comes ceil(d/2) cycles after `busy_i` rises. Ticks then alternate spacings of floor(d/2) and ceil(d/2). `sck_o` starts low, toggles on each tick and changes at no other time while busy.
- R9: While `busy_i` is low, `tick_o` stays low, `sck_o` is forced low one cycle later, and the next frame restarts from its first phase.
- R10: Configuration writes made while `busy_i` is high do not change the period until `busy_i` has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 200 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ena_we_i | input | 1 | Write strobe for the rate/enable word |
| ena_wdata_i | input | 32 | Rate code in [23:20], full-rate enable in [0] |
| spd_we_i | input | 1 | Write strobe for the divisor word |
| spd_wdata_i | input | 32 | Programmable divisor in [13:8] |
| busy_i | input | 1 | Shift engine frame in progress |
| tick_o | output | 1 | One-cycle pulse on each serial clock edge |
| sck_o | output | 1 | Registered serial clock level |

## Verification
The checker assumes that `busy_i` is a clean level from the shift engine, held across a whole frame, and that configuration strobes are single-cycle pulses. It also assumes the divisor it sees while busy is the one latched during the last idle cycle. The stimulus drives every input on the falling clock edge. Before each frame it leaves `busy_i` low for two cycles so that a fresh rate is latched. It makes writes inside a frame only to show that they are held off, and checks the effect once the engine has returned to idle.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned PROG_W   = 6;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned CODE_LSB = 20;
  localparam int unsigned FAST_BIT = 0;
  localparam int unsigned PROG_LSB = 8;

  localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(5);
  localparam logic [CODE_W-1:0] CODE_FAST  = CODE_W'(4);
  localparam logic [CODE_W-1:0] CODE_PROG  = CODE_W'(7);
  localparam int unsigned       N_PRESET   = 6;

  localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(250);
  localparam logic [DIV_W-1:0] DIV_MIN  = DIV_W'(2);

  typedef logic [DIV_W-1:0] div_t;

  function automatic div_t preset_div(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(0): preset_div = DIV_W'(3);
      CODE_W'(1): preset_div = DIV_W'(6);
      CODE_W'(2): preset_div = DIV_W'(9);
      CODE_W'(3): preset_div = DIV_W'(12);
      CODE_W'(4): preset_div = DIV_MIN;
      default:    preset_div = DIV_SLOW;
    endcase
  endfunction
endpackage

// File: rtl/sck_rate_regs.sv
module sck_rate_regs
  import sck_rate_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_we_i,
  input  logic [DATA_W-1:0] ena_wdata_i,
  input  logic              spd_we_i,
  input  logic [DATA_W-1:0] spd_wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fast_en_o,
  output logic [PROG_W-1:0] prog_o
);
  logic [CODE_W-1:0] code_q;
  logic              fast_q;
  logic [PROG_W-1:0] prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_RESET;
      fast_q <= 1'b0;
    end else if (ena_we_i) begin
      code_q <= ena_wdata_i[CODE_LSB +: CODE_W];
      fast_q <= ena_wdata_i[FAST_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prog_q <= '1;
    else if (spd_we_i) prog_q <= spd_wdata_i[PROG_LSB +: PROG_W];
  end

  assign code_o    = code_q;
  assign fast_en_o = fast_q;
  assign prog_o    = prog_q;
endmodule

// File: rtl/sck_div_lookup.sv
module sck_div_lookup
  import sck_rate_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_en_i,
  input  logic [PROG_W-1:0] prog_i,
  output logic [DIV_W-1:0]  div_o
);
  logic [DIV_W-1:0] prog_div;

  // field values below the minimum clamp to the fastest legal divisor
  assign prog_div = (prog_i < PROG_W'(DIV_MIN)) ? DIV_MIN : DIV_W'(prog_i);

  always_comb begin
    if (code_i == CODE_PROG)
      div_o = prog_div;
    else if (code_i == CODE_FAST && !fast_en_i)
      div_o = DIV_SLOW;
    else if (code_i < CODE_W'(N_PRESET))
      div_o = preset_div(code_i);
    else
      div_o = DIV_SLOW;
  end
endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen
  import sck_rate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             busy_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             tick_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] act_q, cnt_q, lo_len, hi_len, idle_len;
  logic             sck_q, tick_q;

  assign lo_len   = act_q - (act_q >> 1);
  assign hi_len   = act_q >> 1;
  assign idle_len = div_i - (div_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= DIV_SLOW;
      cnt_q  <= DIV_SLOW - (DIV_SLOW >> 1);
      sck_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!busy_i) begin
      act_q  <= div_i;
      cnt_q  <= idle_len;
      sck_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (cnt_q <= DIV_W'(1)) begin
      sck_q  <= ~sck_q;
      tick_q <= 1'b1;
      cnt_q  <= sck_q ? lo_len : hi_len;
    end else begin
      cnt_q  <= cnt_q - DIV_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign act_div_o = act_q;
  assign tick_o    = tick_q;
  assign sck_o     = sck_q;
endmodule

// File: rtl/sck_rate_sel.sv
module sck_rate_sel
  import sck_rate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ena_we_i,
  input  logic [31:0] ena_wdata_i,
  input  logic        spd_we_i,
  input  logic [31:0] spd_wdata_i,
  input  logic        busy_i,
  output logic        tick_o,
  output logic        sck_o
);
  logic [CODE_W-1:0] code;
  logic              fast_en;
  logic [PROG_W-1:0] prog;
  logic [DIV_W-1:0]  sel_div;
  logic [DIV_W-1:0]  act_div;

  sck_rate_regs #(.DATA_W(32)) u_regs (
    .clk_i, .rst_ni, .ena_we_i, .ena_wdata_i, .spd_we_i, .spd_wdata_i,
    .code_o(code), .fast_en_o(fast_en), .prog_o(prog)
  );

  sck_div_lookup u_lut (
    .code_i(code), .fast_en_i(fast_en), .prog_i(prog), .div_o(sel_div)
  );

  sck_phase_gen u_gen (
    .clk_i, .rst_ni, .div_i(sel_div), .busy_i,
    .act_div_o(act_div), .tick_o, .sck_o
  );
endmodule

// File: rtl/sck_rate_chk.sv
module sck_rate_chk
  import sck_rate_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             tick_o,
  input logic             sck_o,
  input logic [DIV_W-1:0] act_div
);
  // R9
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !tick_o);
  // R9
  idle_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !sck_o);
  // R8
  tick_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sck_o != $past(sck_o)));
  // R8
  sck_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !tick_o) |-> $stable(sck_o));
  // R10
  rate_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(act_div));
  // R6
  div_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_div >= DIV_MIN);
endmodule

bind sck_rate_sel sck_rate_chk u_chk (
  .clk_i, .rst_ni, .busy_i, .tick_o, .sck_o, .act_div(act_div)
);

// File: tb/test_sck_rate_sel.sv
`timescale 1ns/1ps
module test_sck_rate_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ena_we = 1'b0, spd_we = 1'b0, busy = 1'b0;
  logic [31:0] ena_wd = '0, spd_wd = '0;
  logic tick, sck;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sck_rate_sel i_sck_rate_sel (
    .clk_i(clk), .rst_ni(rst_n), .ena_we_i(ena_we), .ena_wdata_i(ena_wd),
    .spd_we_i(spd_we), .spd_wdata_i(spd_wd), .busy_i(busy),
    .tick_o(tick), .sck_o(sck)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ena(input int code, input bit fast);
    @(negedge clk);
    ena_wd = (32'(code) << 20) | 32'(fast) | 32'h0F00_0F0E;
    ena_we = 1'b1;
    @(negedge clk);
    ena_we = 1'b0;
  endtask

  task automatic wr_spd(input int val);
    @(negedge clk);
    spd_wd = (32'(val) << 8) | 32'hFFFF_C0FF;
    spd_we = 1'b1;
    @(negedge clk);
    spd_we = 1'b0;
  endtask

  // run one frame of two periods, return count of mismatching cycles
  task automatic run_frame(input string req, input int d);
    int lo = d - d / 2, hi = d / 2, nxt = lo, ntk = 0, bad = 0;
    bit ph = 0;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    for (int n = 1; n <= 2 * d; n++) begin
      bit exp_t;
      @(negedge clk);
      exp_t = (n == nxt);
      if (exp_t) begin
        ntk++;
        nxt = n + (ph ? lo : hi);
        ph = ~ph;
      end
      if (tick != exp_t || sck != ph) bad++;
    end
    busy = 1'b0;
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    check("R1 tick", int'(tick), 0);
    check("R1 sck", int'(sck), 0);
    run_frame("R1 default period 250", 250);
  endtask

  task automatic t_presets;
    wr_ena(0, 0); run_frame("R3 code0 d3", 3);
    wr_ena(1, 0); run_frame("R3 code1 d6", 6);
    wr_ena(2, 0); run_frame("R3 code2 d9", 9);
    wr_ena(3, 0); run_frame("R3 code3 d12", 12);
    wr_ena(5, 0); run_frame("R5 code5 d250", 250);
  endtask

  task automatic t_fast;
    wr_ena(4, 1); run_frame("R4 code4 enabled d2", 2);
    wr_ena(4, 0); run_frame("R4 code4 disabled d250", 250);
  endtask

  task automatic t_prog;
    wr_ena(7, 0);
    wr_spd(4);  run_frame("R6 prog 4", 4);
    wr_spd(50); run_frame("R6 prog 50", 50);
    wr_spd(63); run_frame("R6 prog 63", 63);
    wr_spd(0);  run_frame("R6 prog 0 clamps to 2", 2);
    wr_spd(1);  run_frame("R6 prog 1 clamps to 2", 2);
    wr_spd(5);  run_frame("R2 divisor field bits 13:8", 5);
  endtask

  task automatic t_fallback;
    wr_ena(6, 0);  run_frame("R7 code6", 250);
    wr_ena(8, 0);  run_frame("R7 code8", 250);
    wr_ena(15, 1); run_frame("R7 code15", 250);
  endtask

  task automatic t_idle;
    int ticks = 0, hi = 0;
    wr_ena(0, 0);
    repeat (2) @(negedge clk);
    busy = 1'b1;
    repeat (4) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    check("R9 sck low after stop", int'(sck), 0);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (tick) ticks++;
      if (sck) hi++;
    end
    check("R9 no ticks idle", ticks, 0);
    check("R9 sck low idle", hi, 0);
    run_frame("R9 restart from first phase", 3);
  endtask

  task automatic t_freeze;
    int bad = 0, nxt = 2;
    bit ph = 0;
    wr_ena(0, 0);
    repeat (2) @(negedge clk);
    busy = 1'b1;
    for (int n = 1; n <= 30; n++) begin
      bit exp_t;
      @(negedge clk);
      ena_we = (n == 4);
      ena_wd = 32'(3) << 20;
      exp_t = (n == nxt);
      if (exp_t) begin
        nxt = n + (ph ? 2 : 1);
        ph = ~ph;
      end
      if (tick != exp_t || sck != ph) bad++;
    end
    ena_we = 1'b0;
    busy = 1'b0;
    check("R10 write during frame held off", bad, 0);
    run_frame("R10 new rate after idle", 12);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_presets();
    t_fast();
    t_prog();
    t_fallback();
    t_idle();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule